// File: doc/BRIEF.md
# Floating-Point Context Status Tracker

This block keeps the two-bit floating-point context state held in the machine status word. The state has four codes: 0 Off, 1 Initial, 2 Clean and 3 Dirty. Privileged software may load the field directly. Hardware events move it to Dirty. These events are explicit writes to the FP flag CSR, the rounding-mode CSR or the combined FP CSR, writes to the FP register file, and completions of FP compare or convert-to-integer operations. The block also presents the field and a summary-dirty bit in their place in the status word.

A mode parameter, fixed at elaboration, picks one of three policies for marking the state Dirty. In always-dirty mode the field only ever holds Off or Dirty. In write-one mode, which is the default, a compare or convert marks Dirty only when it raises an FP exception. In write-any mode every compare or convert marks Dirty. While the field is Off, the block flags every scalar or vector FP instruction presented to it as illegal, so the decoder can trap.

Top module: `fp_ctx_tracker`

## Requirements
- R1: After reset the field equals the RESET_STATE parameter, which defaults to 0 (Off). In always-dirty mode a non-zero RESET_STATE resets to 3.
- R2: In write-one and write-any modes, a privileged write (csrWrEn=1) stores csrWrVal in the field at the next clock edge.
- R3: In always-dirty mode, a privileged write of 1 or 2 stores 3, a write of 0 stores 0, and the field never holds 1 or 2.
- R4: A pulse on any one of flagCsrWr, rndCsrWr or fullCsrWr sets the field to 3 at the next edge.
- R5: A pulse on fprWr (FP register-file write) sets the field to 3 at the next edge.
- R6: In write-one mode (the default), cmpCvtDone with cmpCvtExc=1 sets the field to 3. With cmpCvtExc=0 it leaves the field unchanged.
- R7: In write-any mode, cmpCvtDone sets the field to 3 whatever the value of cmpCvtExc.
- R8: When a privileged write and a hardware dirty event occur in the same cycle, the privileged write decides the stored value.
- R9: illegalInstr is high in the same cycle that fpInstr or vecFpInstr is high while the field is 0, and is low at every other time.
- R10: statusWord carries the field at bits 14:13 and sdBit at bit XLEN-1, with all other bits 0. sdBit is 1 exactly when the field is 3 or otherCtxDirty is 1.
- R11: With no privileged write and no dirty event, the field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Privileged write to the context field |
| csrWrVal | input | 2 | Value written by the privileged write |
| flagCsrWr | input | 1 | Explicit write to the FP flag CSR |
| rndCsrWr | input | 1 | Explicit write to the rounding-mode CSR |
| fullCsrWr | input | 1 | Explicit write to the combined FP CSR |
| fprWr | input | 1 | FP register-file write |
| cmpCvtDone | input | 1 | FP compare or convert-to-integer completed |
| cmpCvtExc | input | 1 | That operation signalled an FP exception |
| fpInstr | input | 1 | Scalar FP instruction presented |
| vecFpInstr | input | 1 | Vector FP instruction presented |
| otherCtxDirty | input | 1 | Another context field is Dirty |
| fsField | output | 2 | Current context state |
| sdBit | output | 1 | Summary-dirty bit |
| statusWord | output | XLEN | Status-word view of the field and summary bit |
| illegalInstr | output | 1 | FP instruction issued while the field is Off |

## Verification
The assertions check the following on every cycle:
- the priority of a privileged write;
- that register-file and CSR writes mark the field Dirty;
- that the field holds when idle;
- that illegalInstr agrees with the Off state;
- the placement of the field in the status word;
- that the field never holds 1 or 2 in always-dirty mode.

Some behaviour differs between policies, such as a compare with and without an exception flag, or the collapsed values under always-dirty. Only the bench's scenarios show this, because they run four instances side by side on the same stimulus. The same holds for a non-zero reset value.

// File: rtl/fp_ctx_pkg.sv
package fp_ctx_pkg;

  typedef enum logic [1:0] {
    FS_ALWAYS_DIRTY = 2'd0,
    FS_WRITE_ONE    = 2'd1,
    FS_WRITE_ANY    = 2'd2
  } fsMode_e;

  localparam logic [1:0] FS_OFF   = 2'd0;
  localparam logic [1:0] FS_DIRTY = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;      // privileged load, wins over setDirty
    logic [1:0] loadVal;   // value after policy mapping
    logic       setDirty;  // hardware dirty event
  } fsStrobe_t;

endpackage

// File: rtl/fp_ctx_ctrl.sv
module fp_ctx_ctrl
  import fp_ctx_pkg::*;
#(
  parameter fsMode_e MODE = FS_WRITE_ONE
) (
  input  logic       csrWrEn,
  input  logic [1:0] csrWrVal,
  input  logic       flagCsrWr,
  input  logic       rndCsrWr,
  input  logic       fullCsrWr,
  input  logic       fprWr,
  input  logic       cmpCvtDone,
  input  logic       cmpCvtExc,
  output fsStrobe_t  strobe
);

  logic cmpCvtMarks;
  logic [1:0] mappedVal;
  logic explicitEv;

  assign explicitEv = flagCsrWr | rndCsrWr | fullCsrWr | fprWr;

  generate
    if (MODE == FS_WRITE_ANY) begin : g_cmpAny
      logic unusedExc;
      assign unusedExc   = cmpCvtExc;
      assign cmpCvtMarks = cmpCvtDone | (unusedExc & 1'b0);
    end else begin : g_cmpExc
      assign cmpCvtMarks = cmpCvtDone & cmpCvtExc;
    end

    if (MODE == FS_ALWAYS_DIRTY) begin : g_collapse
      assign mappedVal = (csrWrVal == FS_OFF) ? FS_OFF : FS_DIRTY;
    end else begin : g_direct
      assign mappedVal = csrWrVal;
    end
  endgenerate

  always_comb begin
    strobe.load     = csrWrEn;
    strobe.loadVal  = mappedVal;
    strobe.setDirty = explicitEv | cmpCvtMarks;
  end

endmodule

// File: rtl/fp_ctx_dp.sv
module fp_ctx_dp
  import fp_ctx_pkg::*;
#(
  parameter fsMode_e    MODE        = FS_WRITE_ONE,
  parameter logic [1:0] RESET_STATE = 2'd0,
  parameter int         XLEN        = 32,
  parameter int         FS_LSB      = 13
) (
  input  logic            clk,
  input  logic            rstN,
  input  fsStrobe_t       strobe,
  input  logic            fpInstr,
  input  logic            vecFpInstr,
  input  logic            otherCtxDirty,
  output logic [1:0]      fsField,
  output logic            sdBit,
  output logic [XLEN-1:0] statusWord,
  output logic            illegalInstr
);

  localparam logic [1:0] RESET_EFF =
    (MODE == FS_ALWAYS_DIRTY && RESET_STATE != FS_OFF) ? FS_DIRTY : RESET_STATE;

  logic [1:0] fsQ;

  always_ff @(posedge clk) begin
    if (!rstN)                fsQ <= RESET_EFF;
    else if (strobe.load)     fsQ <= strobe.loadVal;
    else if (strobe.setDirty) fsQ <= FS_DIRTY;
  end

  assign fsField      = fsQ;
  assign sdBit        = (fsQ == FS_DIRTY) | otherCtxDirty;
  assign illegalInstr = (fpInstr | vecFpInstr) & (fsQ == FS_OFF);

  always_comb begin
    statusWord               = '0;
    statusWord[FS_LSB +: 2]  = fsQ;
    statusWord[XLEN-1]       = sdBit;
  end

endmodule

// File: rtl/fp_ctx_tracker.sv
module fp_ctx_tracker
  import fp_ctx_pkg::*;
#(
  parameter fsMode_e    MODE        = FS_WRITE_ONE,
  parameter logic [1:0] RESET_STATE = 2'd0,
  parameter int         XLEN        = 32,
  parameter int         FS_LSB      = 13
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrWrEn,
  input  logic [1:0]      csrWrVal,
  input  logic            flagCsrWr,
  input  logic            rndCsrWr,
  input  logic            fullCsrWr,
  input  logic            fprWr,
  input  logic            cmpCvtDone,
  input  logic            cmpCvtExc,
  input  logic            fpInstr,
  input  logic            vecFpInstr,
  input  logic            otherCtxDirty,
  output logic [1:0]      fsField,
  output logic            sdBit,
  output logic [XLEN-1:0] statusWord,
  output logic            illegalInstr
);

  fsStrobe_t strobe;

  fp_ctx_ctrl #(.MODE(MODE)) u_ctrl (
    .csrWrEn    (csrWrEn),
    .csrWrVal   (csrWrVal),
    .flagCsrWr  (flagCsrWr),
    .rndCsrWr   (rndCsrWr),
    .fullCsrWr  (fullCsrWr),
    .fprWr      (fprWr),
    .cmpCvtDone (cmpCvtDone),
    .cmpCvtExc  (cmpCvtExc),
    .strobe     (strobe)
  );

  fp_ctx_dp #(
    .MODE(MODE), .RESET_STATE(RESET_STATE), .XLEN(XLEN), .FS_LSB(FS_LSB)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .fpInstr       (fpInstr),
    .vecFpInstr    (vecFpInstr),
    .otherCtxDirty (otherCtxDirty),
    .fsField       (fsField),
    .sdBit         (sdBit),
    .statusWord    (statusWord),
    .illegalInstr  (illegalInstr)
  );

endmodule

// File: rtl/fp_ctx_checker.sv
module fp_ctx_checker
  import fp_ctx_pkg::*;
#(
  parameter fsMode_e MODE   = FS_WRITE_ONE,
  parameter int      XLEN   = 32,
  parameter int      FS_LSB = 13
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrWrEn,
  input logic [1:0]      csrWrVal,
  input logic            flagCsrWr,
  input logic            rndCsrWr,
  input logic            fullCsrWr,
  input logic            fprWr,
  input logic            cmpCvtDone,
  input logic            fpInstr,
  input logic            vecFpInstr,
  input logic [1:0]      fsField,
  input logic            sdBit,
  input logic [XLEN-1:0] statusWord,
  input logic            illegalInstr
);

  logic anyEvent;
  assign anyEvent = flagCsrWr | rndCsrWr | fullCsrWr | fprWr | cmpCvtDone;

  // R8
  load_off_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrWrVal == 2'd0) |=> fsField == 2'd0);

  // R5
  fpr_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csrWrEn && fprWr) |=> fsField == 2'd3);

  // R4
  csr_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csrWrEn && (flagCsrWr || rndCsrWr || fullCsrWr)) |=> fsField == 2'd3);

  // R11
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csrWrEn && !anyEvent) |=> $stable(fsField));

  // R9
  illegal_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((fpInstr || vecFpInstr) && fsField == 2'd0) |-> illegalInstr);

  // R9
  legal_when_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsField != 2'd0) |-> !illegalInstr);

  // R10
  field_placed_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[FS_LSB +: 2] == fsField && statusWord[XLEN-1] == sdBit);

  // R10
  dirty_sets_sd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsField == 2'd3) |-> sdBit);

  // R3
  two_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (MODE != FS_ALWAYS_DIRTY) || fsField == 2'd0 || fsField == 2'd3);

endmodule

bind fp_ctx_tracker fp_ctx_checker #(.MODE(MODE), .XLEN(XLEN), .FS_LSB(FS_LSB)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .csrWrEn      (csrWrEn),
  .csrWrVal     (csrWrVal),
  .flagCsrWr    (flagCsrWr),
  .rndCsrWr     (rndCsrWr),
  .fullCsrWr    (fullCsrWr),
  .fprWr        (fprWr),
  .cmpCvtDone   (cmpCvtDone),
  .fpInstr      (fpInstr),
  .vecFpInstr   (vecFpInstr),
  .fsField      (fsField),
  .sdBit        (sdBit),
  .statusWord   (statusWord),
  .illegalInstr (illegalInstr)
);

// File: tb/fp_ctx_tracker_bench.sv
module fp_ctx_tracker_bench;
  import fp_ctx_pkg::*;

  logic clk = 1'b0;
  logic rstN;
  logic csrWrEn, flagCsrWr, rndCsrWr, fullCsrWr, fprWr;
  logic cmpCvtDone, cmpCvtExc, fpInstr, vecFpInstr, otherCtxDirty;
  logic [1:0] csrWrVal;

  logic [1:0]  fsW1, fsAd, fsWa, fsRs;
  logic        sdW1, sdAd, sdWa, sdRs;
  logic [31:0] swW1, swAd, swWa, swRs;
  logic        ilW1, ilAd, ilWa, ilRs;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fp_ctx_tracker u_fp_ctx_tracker (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrVal(csrWrVal),
    .flagCsrWr(flagCsrWr), .rndCsrWr(rndCsrWr), .fullCsrWr(fullCsrWr),
    .fprWr(fprWr), .cmpCvtDone(cmpCvtDone), .cmpCvtExc(cmpCvtExc),
    .fpInstr(fpInstr), .vecFpInstr(vecFpInstr), .otherCtxDirty(otherCtxDirty),
    .fsField(fsW1), .sdBit(sdW1), .statusWord(swW1), .illegalInstr(ilW1));

  fp_ctx_tracker #(.MODE(FS_ALWAYS_DIRTY)) u_fp_ctx_tracker_ad (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrVal(csrWrVal),
    .flagCsrWr(flagCsrWr), .rndCsrWr(rndCsrWr), .fullCsrWr(fullCsrWr),
    .fprWr(fprWr), .cmpCvtDone(cmpCvtDone), .cmpCvtExc(cmpCvtExc),
    .fpInstr(fpInstr), .vecFpInstr(vecFpInstr), .otherCtxDirty(otherCtxDirty),
    .fsField(fsAd), .sdBit(sdAd), .statusWord(swAd), .illegalInstr(ilAd));

  fp_ctx_tracker #(.MODE(FS_WRITE_ANY)) u_fp_ctx_tracker_wa (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrVal(csrWrVal),
    .flagCsrWr(flagCsrWr), .rndCsrWr(rndCsrWr), .fullCsrWr(fullCsrWr),
    .fprWr(fprWr), .cmpCvtDone(cmpCvtDone), .cmpCvtExc(cmpCvtExc),
    .fpInstr(fpInstr), .vecFpInstr(vecFpInstr), .otherCtxDirty(otherCtxDirty),
    .fsField(fsWa), .sdBit(sdWa), .statusWord(swWa), .illegalInstr(ilWa));

  fp_ctx_tracker #(.RESET_STATE(2'd2)) u_fp_ctx_tracker_rs (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrVal(csrWrVal),
    .flagCsrWr(flagCsrWr), .rndCsrWr(rndCsrWr), .fullCsrWr(fullCsrWr),
    .fprWr(fprWr), .cmpCvtDone(cmpCvtDone), .cmpCvtExc(cmpCvtExc),
    .fpInstr(fpInstr), .vecFpInstr(vecFpInstr), .otherCtxDirty(otherCtxDirty),
    .fsField(fsRs), .sdBit(sdRs), .statusWord(swRs), .illegalInstr(ilRs));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleIn();
    csrWrEn = 0; csrWrVal = 0; flagCsrWr = 0; rndCsrWr = 0; fullCsrWr = 0;
    fprWr = 0; cmpCvtDone = 0; cmpCvtExc = 0; fpInstr = 0; vecFpInstr = 0;
    otherCtxDirty = 0;
  endtask

  // Inputs are set at a falling edge; one rising edge updates the field.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idleIn();
  endtask

  task automatic loadField(input logic [1:0] v);
    csrWrEn = 1; csrWrVal = v;
    tick();
  endtask

  task automatic tReset();
    check("R1", "default reset", {30'd0, fsW1}, 32'd0);
    check("R1", "reset param", {30'd0, fsRs}, 32'd2);
    check("R1", "always-dirty reset", {30'd0, fsAd}, 32'd0);
    check("R10", "status word after reset", swW1, 32'd0);
  endtask

  task automatic tLoad();
    loadField(2'd1);
    check("R2", "write-one load 1", {30'd0, fsW1}, 32'd1);
    check("R2", "write-any load 1", {30'd0, fsWa}, 32'd1);
    check("R3", "always-dirty load 1", {30'd0, fsAd}, 32'd3);
    loadField(2'd2);
    check("R2", "write-one load 2", {30'd0, fsW1}, 32'd2);
    check("R3", "always-dirty load 2", {30'd0, fsAd}, 32'd3);
    loadField(2'd0);
    check("R3", "always-dirty load 0", {30'd0, fsAd}, 32'd0);
  endtask

  task automatic tHold();
    loadField(2'd2);
    tick(); tick(); tick();
    check("R11", "hold clean", {30'd0, fsW1}, 32'd2);
    check("R11", "hold reset param copy", {30'd0, fsRs}, 32'd2);
  endtask

  task automatic tFpCsrWrites();
    for (int k = 0; k < 3; k++) begin
      loadField(2'd1);
      flagCsrWr = (k == 0); rndCsrWr = (k == 1); fullCsrWr = (k == 2);
      tick();
      check("R4", $sformatf("explicit CSR write %0d", k), {30'd0, fsW1}, 32'd3);
    end
  endtask

  task automatic tFprWrite();
    loadField(2'd2);
    fprWr = 1;
    tick();
    check("R5", "register write", {30'd0, fsW1}, 32'd3);
    check("R5", "register write always-dirty", {30'd0, fsAd}, 32'd3);
  endtask

  task automatic tCmpCvt();
    loadField(2'd2);
    cmpCvtDone = 1; cmpCvtExc = 0;
    tick();
    check("R6", "compare no exception write-one", {30'd0, fsW1}, 32'd2);
    check("R7", "compare no exception write-any", {30'd0, fsWa}, 32'd3);
    cmpCvtDone = 1; cmpCvtExc = 1;
    tick();
    check("R6", "compare with exception write-one", {30'd0, fsW1}, 32'd3);
  endtask

  task automatic tPriority();
    loadField(2'd3);
    csrWrEn = 1; csrWrVal = 2'd1; fprWr = 1; flagCsrWr = 1;
    tick();
    check("R8", "load beats dirty event", {30'd0, fsW1}, 32'd1);
    csrWrEn = 1; csrWrVal = 2'd0; cmpCvtDone = 1; cmpCvtExc = 1;
    tick();
    check("R8", "load off beats compare", {30'd0, fsWa}, 32'd0);
    check("R8", "load off always-dirty", {30'd0, fsAd}, 32'd0);
  endtask

  task automatic tIllegal();
    loadField(2'd0);
    vecFpInstr = 1;
    #1;
    check("R9", "vector FP while off", {31'd0, ilW1}, 32'd1);
    vecFpInstr = 0; fpInstr = 1;
    #1;
    check("R9", "scalar FP while off", {31'd0, ilW1}, 32'd1);
    fpInstr = 0;
    #1;
    check("R9", "no FP instruction", {31'd0, ilW1}, 32'd0);
    loadField(2'd2);
    fpInstr = 1; vecFpInstr = 1;
    #1;
    check("R9", "FP while clean", {31'd0, ilW1}, 32'd0);
    idleIn();
  endtask

  task automatic tStatus();
    loadField(2'd3);
    check("R10", "dirty status", swW1, 32'h8000_6000);
    loadField(2'd1);
    otherCtxDirty = 1;
    #1;
    check("R10", "other dirty status", swW1, 32'h8000_2000);
    otherCtxDirty = 0;
    #1;
    check("R10", "initial status", swW1, 32'h0000_2000);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idleIn();
    rstN = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tLoad();
    tHold();
    tFpCsrWrites();
    tFprWrite();
    tCmpCvt();
    tPriority();
    tIllegal();
    tStatus();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule